// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable logic cell of the kind repeated across a gate-array fabric. It has two 3-input lookup tables, a 2:1 mux that joins them, a one-bit full adder with carry in and carry out, a D flip-flop and two output-path muxes. A 19-bit configuration word sets both truth tables, the operating mode, the choice between the lookup path and the adder sum, and whether the output is registered.

In normal mode the fourth logic input picks between the two lookup tables, so the cell computes any function of four inputs. In arithmetic mode the two table outputs are the adder operands and the carry comes from a neighbouring cell, so cells chain into a ripple adder.

The configuration is shifted in one bit per clock, least significant bit first, while the load enable is high. It takes effect when the load enable falls. The load pins are plain control pins: the serial port has no valid/ready handshake and no back-pressure, so the bit is taken on every clock while the enable is high. The logic inputs and the outputs are also plain levels and are not streams.

Top module: `clb_cell`

## Requirements
- R1: The three low logic inputs form the index {din[2],din[1],din[0]} into both tables; configuration bits [7:0] hold table A and bits [15:8] hold table B, where bit k is the output for index k.
- R2: In normal mode (configuration bit 16 = 0) with bit 17 = 0, the data result is table A's output when din[3] = 0 and table B's output when din[3] = 1, so the XOR of all four inputs is realisable.
- R3: In arithmetic mode (bit 16 = 1) the adder adds table A's output, table B's output and carry_i, and with bit 17 = 1 the data result is the sum bit.
- R4: carry_o is the majority of the two table outputs and carry_i in arithmetic mode, and is 0 in normal mode whatever carry_i is.
- R5: With bit 18 = 0, dout follows the data result with no clock delay. With bit 18 = 1, dout shows the data result that was captured at the last rising clock edge.
- R6: While cfg_en is high, cfg_bit is shifted in on each rising edge, least significant bit first. The new word replaces the active configuration at the first rising edge where cfg_en is low after being high. Before that edge the cell keeps its old behaviour.
- R7: A synchronous active-high rst clears the flip-flop to 0 and leaves the active configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flip-flop |
| din | input | 4 | Logic inputs; [2:0] index the tables, [3] joins them |
| carry_i | input | 1 | Carry from the neighbouring cell |
| cfg_en | input | 1 | Serial configuration load enable |
| cfg_bit | input | 1 | Serial configuration data, LSB first |
| dout | output | 1 | Cell output |
| carry_o | output | 1 | Carry to the next cell |

## Verification
The assertions check on every cycle that carry_o is zero in normal mode, that a registered output equals the data result of the cycle before, that the active configuration does not move while a load is in progress, that each serial bit lands in the top of the shadow word, and that the flip-flop is clear after reset. Some behaviours can only be shown by the bench's scenarios. These are the truth-table indexing, the full four-input function, the arithmetic results over all operand and carry combinations, the cell keeping its old function during a partial load, and the configuration surviving reset.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int LUT_IN   = 3;
  localparam int LUT_BITS = 1 << LUT_IN;
  localparam int CFG_W    = 2 * LUT_BITS + 3;

  typedef struct packed {
    logic                reg_out;
    logic                sel_sum;
    logic                arith;
    logic [LUT_BITS-1:0] lut_b;
    logic [LUT_BITS-1:0] lut_a;
  } clb_cfg_t;
endpackage

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain
  import clb_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_bit,
  output logic [W-1:0] active
);
  logic [W-1:0] shadow_q = '0;
  logic [W-1:0] active_q = '0;
  logic         en_q     = 1'b0;

  always_ff @(posedge clk) begin
    en_q <= cfg_en;
    if (cfg_en) shadow_q <= {cfg_bit, shadow_q[W-1:1]};
    if (en_q && !cfg_en) active_q <= shadow_q;
  end

  assign active = active_q;

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_en) |-> $stable(active_q));

  // R6
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> shadow_q[W-1] == $past(cfg_bit));
endmodule

// File: rtl/clb_lut.sv
module clb_lut #(
  parameter int N = 3,
  localparam int DEPTH = 1 << N
) (
  input  logic [DEPTH-1:0] table_bits,
  input  logic [N-1:0]     idx,
  output logic             y
);
  assign y = table_bits[idx];
endmodule

// File: rtl/clb_full_add.sv
module clb_full_add (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/clb_cell.sv
module clb_cell
  import clb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] din,
  input  logic       carry_i,
  input  logic       cfg_en,
  input  logic       cfg_bit,
  output logic       dout,
  output logic       carry_o
);
  logic [CFG_W-1:0] cfg_raw;
  clb_cfg_t         cfg;
  logic [1:0]       lut_y;
  logic             join_y, sum_y, co_y, adder_ci, data_w;
  logic             ff_q;

  clb_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .active(cfg_raw)
  );
  assign cfg = clb_cfg_t'(cfg_raw);

  for (genvar g = 0; g < 2; g++) begin : g_lut
    clb_lut #(.N(LUT_IN)) u_lut (
      .table_bits(g == 0 ? cfg.lut_a : cfg.lut_b),
      .idx(din[LUT_IN-1:0]),
      .y(lut_y[g])
    );
  end

  // first mux: fourth input joins the two tables
  assign join_y   = din[3] ? lut_y[1] : lut_y[0];
  assign adder_ci = cfg.arith & carry_i;

  clb_full_add u_fa (
    .a(lut_y[0]), .b(lut_y[1]), .ci(adder_ci), .s(sum_y), .co(co_y)
  );

  // second mux: table path or adder sum
  assign data_w  = cfg.sel_sum ? sum_y : join_y;
  assign carry_o = cfg.arith & co_y;

  always_ff @(posedge clk) begin
    if (rst) ff_q <= 1'b0;
    else     ff_q <= data_w;
  end

  // third mux: combinational or registered
  assign dout = cfg.reg_out ? ff_q : data_w;

  // R4
  cout_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg.arith |-> !carry_o);

  // R5
  reg_out_chk: assert property (@(posedge clk) disable iff (rst)
    cfg.reg_out |=> (dout == $past(data_w)) || !cfg.reg_out);

  // R7
  ff_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ff_q == 1'b0);
endmodule

// File: tb/clb_cell_tb.sv
module clb_cell_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] din = '0;
  logic       carry_i = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_bit = 1'b0;
  logic       dout, carry_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  clb_cell u_dut (
    .clk(clk), .rst(rst), .din(din), .carry_i(carry_i),
    .cfg_en(cfg_en), .cfg_bit(cfg_bit), .dout(dout), .carry_o(carry_o)
  );

  always #2.5 clk = ~clk;

  // {reg_out, sel_sum, arith, lut_b, lut_a}
  localparam logic [18:0] XOR_C = {3'b000, 8'h69, 8'h96};
  localparam logic [18:0] XOR_R = {3'b100, 8'h69, 8'h96};
  localparam logic [18:0] ADD_C = {3'b011, 8'hCC, 8'hAA};
  localparam logic [18:0] ADD_R = {3'b111, 8'hCC, 8'hAA};
  localparam logic [19:0] CASES [4] = '{
    {XOR_C, 1'b0}, {XOR_R, 1'b0}, {ADD_C, 1'b1}, {ADD_R, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [18:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_bit = w[i];
    end
  endtask

  task automatic finish_load();
    @(negedge clk);
    cfg_en = 1'b0;
    @(posedge clk);
  endtask

  task automatic load(input logic [18:0] w);
    shift_bits(w, 19);
    finish_load();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7: reset state with the all-zero configuration
    #1 check(dout == 1'b0 && carry_o == 1'b0, "R7 reset state", dout, 0);

    // table walk: R1 R2 R3 R4 R5
    for (int c = 0; c < 4; c++) begin
      logic [18:0] w;
      bit          is_add;
      w      = CASES[c][19:1];
      is_add = CASES[c][0];
      load(w);
      for (int v = 0; v < 32; v++) begin
        logic [1:0] tot;
        logic       exp_o, exp_c;
        @(negedge clk);
        din     = v[3:0];
        carry_i = v[4];
        if (is_add) begin
          tot   = {1'b0, v[0]} + {1'b0, v[1]} + {1'b0, v[4]};
          exp_o = tot[0];
          exp_c = tot[1];
        end else begin
          exp_o = ^v[3:0];
          exp_c = 1'b0;
        end
        if (w[18]) @(posedge clk);
        #1;
        if (is_add) check(dout == exp_o, w[18] ? "R3 R5 registered sum" : "R3 sum", dout, exp_o);
        else check(dout == exp_o, w[18] ? "R2 R5 registered xor" : "R1 R2 xor", dout, exp_o);
        check(carry_o == exp_c, "R4 carry_o", carry_o, exp_c);
      end
    end

    // R5: registered output holds until the next edge
    load(XOR_R);
    @(negedge clk); din = 4'b0001; carry_i = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); din = 4'b0011;
    #1 check(dout == 1'b1, "R5 held between edges", dout, 1);
    @(posedge clk); #1 check(dout == 1'b0, "R5 captured at edge", dout, 0);

    // R7: reset clears the flip-flop, configuration kept
    @(negedge clk); din = 4'b0001; rst = 1'b1;
    @(posedge clk); #1 check(dout == 1'b0, "R7 flip-flop cleared", dout, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1 check(dout == 1'b1, "R7 config kept after reset", dout, 1);

    // R6: partial load does not disturb the old function
    load(XOR_C);
    @(negedge clk); din = 4'b0111; carry_i = 1'b0;
    shift_bits(ADD_C, 10);
    #1 check(dout == 1'b1, "R6 old function during load", dout, 1);
    check(carry_o == 1'b0, "R6 old carry during load", carry_o, 0);
    shift_bits(ADD_C >> 10, 9);
    @(posedge clk); #1 check(dout == 1'b1, "R6 not applied while enable high", dout, 1);
    finish_load();
    #1 check(dout == 1'b0, "R6 applied after enable falls", dout, 0);
    check(carry_o == 1'b1, "R6 R4 new carry", carry_o, 1);

    // R4: carry_i ignored in normal mode with adder sum selected
    load({3'b010, 8'hCC, 8'hAA});
    @(negedge clk); din = 4'b0001; carry_i = 1'b1;
    #1 check(dout == 1'b1, "R4 normal-mode carry ignored in sum", dout, 1);
    check(carry_o == 1'b0, "R4 normal-mode carry_o", carry_o, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule